// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block runs the high-speed transmitter slew-rate calibration for a single port. A start pulse makes it power the ring oscillator, let it settle, switch on the free-running clock and program a measurement window into an external frequency meter. It then enables the meter and waits for a valid indication, giving up after a bounded time. After that it takes the meter's count, turns the meter and the clock off, derives a 3-bit slew-rate code in hardware and presents it. The oscillator is switched off last.

The code is the rounded value of reference MHz times coefficient times the window length, divided by the measured count and then by 1000. The first division truncates. The second rounds to nearest by adding 500 before dividing. A zero count selects a default code of 3. A result above 7 is held at 7. When a nonzero forced code is present at start, the whole measurement is skipped and the forced code is presented at once. The meter itself sits outside the block.

Top module: `slew_cal_seq`

## Requirements
- R1: After reset, osc_en_o, frck_en_o, fm_en_o and done_o are 0, fm_win_o is 0 and code_o is 0.
- R2: A start with force_code_i nonzero never raises osc_en_o, loads code_o with force_code_i and pulses done_o one cycle after the start.
- R3: osc_en_o is high for at least CLK_MHZ*SETTLE_US cycles before frck_en_o rises. While fm_en_o is high, frck_en_o is high and fm_win_o equals WIN_CYCLES (1024).
- R4: For a nonzero count N the code is ((ref*coef*1024/N, truncated) + 500)/1000, truncated.
- R5: If fm_valid_i never rises, the wait ends after CLK_MHZ*TIMEOUT_US cycles of fm_en_o. The sequence then continues with the fm_count_i value present at that time.
- R6: A captured count of zero gives code 3.
- R7: A computed code above 7 is presented as 7.
- R8: done_o is a one-cycle pulse. It coincides with the fall of osc_en_o, and code_o already holds its final value in the last cycle osc_en_o is high.
- R9: A start while a sequence is running is ignored: there is no extra done_o and no change to the result.
- R10: frck_en_o falls in the same cycle as fm_en_o, before the code is computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| ref_mhz_i | input | REF_W | Reference frequency in MHz |
| coef_i | input | COEF_W | Slew-rate coefficient |
| force_code_i | input | CODE_W | Forced code; nonzero skips calibration |
| fm_valid_i | input | 1 | Meter result valid |
| fm_count_i | input | CNT_W | Meter count |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Free-running clock enable |
| fm_en_o | output | 1 | Frequency meter enable |
| fm_win_o | output | WIN_W | Meter window length in cycles |
| code_o | output | CODE_W | Slew-rate code |
| done_o | output | 1 | Sequence finished pulse |

## Verification
Counts of 110 and 100 give codes 4 and 5. This shows that the dividend and the divisor are not swapped. A count of 300 gives a quotient of 1508, and the result of 2 can only come from adding 500 before the division by 1000. A count of 1 saturates the code, a count of 0 selects the default, and a meter that never answers exercises the timeout path with a held count. Runs with forced codes, and a second start injected while a run is busy, separate the skip path from the ignore rule.

// File: rtl/slew_cal_pkg.sv
package slew_cal_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETTLE, ST_CLKEN, ST_LOAD, ST_MEAS,
    ST_CAPT, ST_DIV1, ST_DIV2, ST_WRITE, ST_FIN
  } st_e;
  localparam int unsigned SR_DIVISOR = 1000;
  localparam int unsigned SR_HALF    = SR_DIVISOR / 2;
endpackage

// File: rtl/slew_cal_div.sv
module slew_cal_div #(
  parameter int W = 27
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [W:0]    shl, diff;
  logic          fit;

  always_comb begin
    shl  = {rem_q, quo_q[W-1]};
    fit  = shl >= {1'b0, dvs_q};
    diff = shl - {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(W);
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dvs_q  <= divisor_i;
      end else if (busy_q) begin
        rem_q <= fit ? diff[W-1:0] : shl[W-1:0];
        quo_q <= {quo_q[W-2:0], fit};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;

  assert_div_no_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  assert_div_rem_below_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rem_q < dvs_q);
endmodule

// File: rtl/slew_cal_tmr.sv
module slew_cal_tmr #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  assert_tmr_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && val_i != '0) |=> !zero_o);
endmodule

// File: rtl/slew_cal_seq.sv
module slew_cal_seq
  import slew_cal_pkg::*;
#(
  parameter int CLK_MHZ    = 50,
  parameter int SETTLE_US  = 1,
  parameter int TIMEOUT_US = 200,
  parameter int WIN_CYCLES = 1024,
  parameter int WIN_W      = 24,
  parameter int CNT_W      = 24,
  parameter int REF_W      = 8,
  parameter int COEF_W     = 8,
  parameter int CODE_W     = 3,
  parameter int DEF_CODE   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REF_W-1:0]  ref_mhz_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [CODE_W-1:0] force_code_i,
  input  logic              fm_valid_i,
  input  logic [CNT_W-1:0]  fm_count_i,
  output logic              osc_en_o,
  output logic              frck_en_o,
  output logic              fm_en_o,
  output logic [WIN_W-1:0]  fm_win_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int TO_CYC     = CLK_MHZ * TIMEOUT_US;
  localparam int TMR_W      = $clog2(TO_CYC + SETTLE_CYC + 1);
  localparam int NUM_W      = REF_W + COEF_W + $clog2(WIN_CYCLES) + 1;
  localparam int CODE_MAX   = (1 << CODE_W) - 1;

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              div_start, div_done;
  logic [NUM_W-1:0]  div_a, div_b, quot, num1;
  logic              go;

  assign go   = (st_q == ST_IDLE) && start_i;
  assign num1 = NUM_W'(ref_mhz_i) * NUM_W'(coef_i) * NUM_W'(WIN_CYCLES);

  assign tmr_load = (go && force_code_i == '0) || (st_q == ST_LOAD);
  assign tmr_val  = (st_q == ST_IDLE) ? TMR_W'(SETTLE_CYC) : TMR_W'(TO_CYC);

  slew_cal_tmr #(.W(TMR_W)) u_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (tmr_load),
    .val_i (tmr_val), .zero_o (tmr_zero)
  );

  // Shared divider: count stage, then rounding stage.
  assign div_start = ((st_q == ST_CAPT) && cnt_q != '0) || ((st_q == ST_DIV1) && div_done);
  assign div_a     = (st_q == ST_CAPT) ? num1 : quot + NUM_W'(SR_HALF);
  assign div_b     = (st_q == ST_CAPT) ? NUM_W'(cnt_q) : NUM_W'(SR_DIVISOR);

  slew_cal_div #(.W(NUM_W)) u_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (div_start),
    .dividend_i (div_a), .divisor_i (div_b), .quot_o (quot), .done_o (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (force_code_i != '0) begin
            code_q <= force_code_i;
            st_q   <= ST_FIN;
          end else st_q <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_zero) st_q <= ST_CLKEN;
        ST_CLKEN:  st_q <= ST_LOAD;
        ST_LOAD:   st_q <= ST_MEAS;
        ST_MEAS: if (fm_valid_i || tmr_zero) begin
          cnt_q <= fm_count_i;
          st_q  <= ST_CAPT;
        end
        ST_CAPT: if (cnt_q == '0) begin
          code_q <= CODE_W'(DEF_CODE);
          st_q   <= ST_WRITE;
        end else st_q <= ST_DIV1;
        ST_DIV1: if (div_done) st_q <= ST_DIV2;
        ST_DIV2: if (div_done) begin
          code_q <= (quot > NUM_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : quot[CODE_W-1:0];
          st_q   <= ST_WRITE;
        end
        ST_WRITE: st_q <= ST_FIN;
        ST_FIN:   st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign osc_en_o  = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign frck_en_o = (st_q == ST_CLKEN) || (st_q == ST_LOAD) || (st_q == ST_MEAS);
  assign fm_en_o   = (st_q == ST_MEAS);
  assign fm_win_o  = ((st_q == ST_LOAD) || (st_q == ST_MEAS)) ? WIN_W'(WIN_CYCLES) : '0;
  assign code_o    = code_q;
  assign done_o    = (st_q == ST_FIN);

  assert_force_skips_osc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && force_code_i != '0) |=> (!osc_en_o && done_o && code_o == $past(force_code_i)));
  assert_meter_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fm_en_o |-> (frck_en_o && osc_en_o && fm_win_o == WIN_W'(WIN_CYCLES)));
  assert_clk_after_osc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frck_en_o) |-> $past(osc_en_o));
  assert_zero_default_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WRITE && cnt_q == '0) |-> code_o == CODE_W'(DEF_CODE));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_osc_off_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> (done_o && $stable(code_o)));
  assert_code_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> (st_q == ST_WRITE || done_o));
  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q != ST_IDLE && st_q != ST_WRITE) |=> !done_o);
  assert_clk_off_with_meter_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fm_en_o) |-> !frck_en_o);
endmodule

// File: tb/slew_cal_seq_test.sv
module slew_cal_seq_test;
  localparam int SETTLE_CYC = 50;
  localparam int TO_CYC     = 10000;

  typedef struct {
    int code;
    bit forced;
    bit tmo;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  ref_mhz = 8'd26;
  logic [7:0]  coef = 8'd17;
  logic [2:0]  force_code = '0;
  logic        fm_valid = 1'b0;
  logic [23:0] fm_count = '0;
  logic        osc_en, frck_en, fm_en, done;
  logic [23:0] fm_win;
  logic [2:0]  code;

  int   n_chk = 0, n_fail = 0, n_done = 0, n_push = 0;
  int   m_delay = 0, mcnt = 0;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  slew_cal_seq uut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .ref_mhz_i (ref_mhz),
    .coef_i (coef), .force_code_i (force_code), .fm_valid_i (fm_valid),
    .fm_count_i (fm_count), .osc_en_o (osc_en), .frck_en_o (frck_en),
    .fm_en_o (fm_en), .fm_win_o (fm_win), .code_o (code), .done_o (done)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(int r, int c, int f, int n);
    int t, q;
    if (f != 0) return f;
    if (n == 0) return 3;
    t = (r * c * 1024) / n;
    q = (t + 500) / 1000;
    return (q > 7) ? 7 : q;
  endfunction

  // Meter model
  always @(negedge clk) begin
    if (!fm_en) begin
      fm_valid <= 1'b0;
      mcnt     <= 0;
    end else begin
      mcnt <= mcnt + 1;
      if (m_delay >= 0 && mcnt >= m_delay) fm_valid <= 1'b1;
    end
  end

  // Monitor
  int   osc_cyc = 0, fm_cyc = 0, settle_seen = -1, last_osc_code = 0;
  bit   osc_seen = 0, win_bad = 0, clk_late = 0, fm_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (osc_en) begin osc_seen = 1; last_osc_code = code; end
      if (osc_en && !frck_en && settle_seen < 0) osc_cyc++;
      if (frck_en && settle_seen < 0) settle_seen = osc_cyc;
      if (fm_en) begin
        fm_cyc++;
        if (!frck_en || fm_win != 24'd1024) win_bad = 1;
      end
      if (fm_prev && !fm_en && frck_en) clk_late = 1;
      fm_prev = fm_en;
      if (done) begin
        exp_t e;
        n_done++;
        if (exp_q.size() == 0) check("R9 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          check("R4/R6/R7 code", code, e.code);
          check("R8 osc low at done", osc_en, 0);
          if (e.forced) check("R2 no osc on forced run", osc_seen, 0);
          else begin
            check("R8 code final before osc off", last_osc_code, e.code);
            check("R3 settle long enough", settle_seen >= SETTLE_CYC, 1);
            check("R3 meter gating", win_bad, 0);
            check("R10 clock off with meter", clk_late, 0);
            if (e.tmo) check("R5 timeout length", fm_cyc >= TO_CYC, 1);
          end
        end
        osc_cyc = 0; fm_cyc = 0; settle_seen = -1; osc_seen = 0;
        win_bad = 0; clk_late = 0;
      end
    end
  end

  task automatic run(int r, int c, int f, int n, int dly, bit poke);
    exp_t e;
    int d0;
    @(negedge clk);
    ref_mhz = 8'(r); coef = 8'(c); force_code = 3'(f);
    fm_count = 24'(n); m_delay = dly;
    e.code = exp_code(r, c, f, n); e.forced = (f != 0); e.tmo = (dly < 0);
    exp_q.push_back(e); n_push++;
    d0 = n_done;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      force_code = 3'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0; force_code = 3'(f);
    end
    while (n_done == d0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset osc/clk/meter/done", {osc_en, frck_en, fm_en, done}, 0);
    check("R1 reset window", fm_win, 0);
    check("R1 reset code", code, 0);
    run(26, 17, 5, 0, 0, 0);     // R2 forced
    run(26, 17, 0, 110, 20, 0);  // R4 -> 4
    run(26, 17, 0, 100, 7, 0);   // R4 -> 5
    run(26, 17, 0, 300, 3, 0);   // R4 rounding 1508 -> 2
    run(40, 20, 0, 300, 12, 0);  // R4 -> 3
    run(26, 17, 0, 0, 5, 0);     // R6 default
    run(26, 17, 0, 1, 2, 0);     // R7 clamp
    run(26, 17, 0, 120, -1, 0);  // R5 timeout -> 4
    run(26, 17, 0, 110, 20, 1);  // R9 start while busy
    run(26, 17, 7, 0, 0, 0);     // R2 forced 7
    repeat (10) @(negedge clk);
    check("R9 done count", n_done, n_push);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule